// File: doc/BRIEF.md
# Interleaved-Parity Protected RAM

This block is a synchronous single-port word store that keeps a small set of parity bits next to every data word. Each parity bit covers an interleaved slice of the word, so a burst of neighbouring bit flips spreads across different slices and is caught. Every read returns the stored word together with an error flag in the same response cycle. Detected errors are collected in sticky status bits, one per severity class, and can drive per-class interrupt lines.

A small register port gives test software one-shot hooks that corrupt the parity on the next write or invert the check on the next read. The hooks never touch data bits. When the store serves as a cache array, a cache-mode setting turns every parity failure into a miss and drops the line's valid bit, so the owner refills the line.

Top module: `parity_guard_ram`

## Requirements
- R1: Parity bit k of a word is the XOR of data bits i with i mod NGRP equal to k (NGRP is at least 4). A word written and read back without injection returns the written data with rsp_perr at 0. Two flips inside one group, for example bits 0 and NGRP, are not flagged.
- R2: Any corruption of 1 to NGRP adjacent stored data bits is flagged by rsp_perr on the read, and the corrupted stored word is returned as it is.
- R3: Writing 1 to bit 0 of register 0 arms write-side injection. The next write then stores every parity bit inverted and disarms. A later read of that word flags an error and returns the true data. An arm written in the same cycle as a write takes effect only for the following write.
- R4: Writing 1 to bit 1 of register 0 arms read-side injection. The next read has its error result inverted and disarms. A clean word then reports an error with the true data, and a word stored with inverted parity reports none. Register 0 reads back the two arm bits.
- R5: Register 1 bits [2:0] are sticky error flags: bit 0 correctable, bit 1 non-fatal, bit 2 fatal. Writing 1 to a bit clears it, and writing 0 leaves it. An error that sets a bit in the same cycle as a clear of that bit leaves it set.
- R6: Register 2 bits [1:0] choose the class that a read error sets: 0 correctable, 1 non-fatal, 2 or 3 fatal.
- R7: irq[2:0] equals the status bits ANDed with the enable bits in register 3 [2:0], with the same bit order as the status.
- R8: With register 2 bit 4 set (cache mode), rsp_miss is 1 on a read whose line is invalid or whose check fails. A failing read clears that line's valid bit, so a later clean read of it still misses until the line is written again. With cache mode off, rsp_miss stays 0.
- R9: A read request produces rsp_valid, rsp_rdata and rsp_perr in the cycle after it is sampled. A write produces no response. Status changes one cycle after the failing response.
- R10: After reset the arm, status, class, cache-mode and enable bits are 0, irq is 0 and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | DW | Stored word |
| rsp_perr | output | 1 | Parity check failed |
| rsp_miss | output | 1 | Cache-mode miss |
| csr_write | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data (combinational) |
| irq | output | 3 | Interrupt lines: correctable, non-fatal, fatal |

## Verification
Two events can land in the same cycle. A failing read response can set a status bit while software writes 1 to clear that bit, and an injection arm can be written while the access that would consume it is being accepted. The bench creates the first case by pulsing the clear in the exact response cycle of a read that is armed to fail, and expects the bit to survive. It creates the second by pairing an arm write with a write request, and expects that word to read back clean while the arm stays pending for the next write.

// File: rtl/parity_guard_ram.sv
module parity_guard_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int NGRP  = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_perr,
  output logic          rsp_miss,
  input  logic          csr_write,
  input  logic [1:0]    csr_addr,
  input  logic [7:0]    csr_wdata,
  output logic [7:0]    csr_rdata,
  output logic [2:0]    irq
);

  function automatic logic [NGRP-1:0] grp_par(input logic [DW-1:0] d);
    logic [NGRP-1:0] p;
    p = '0;
    for (int i = 0; i < DW; i++) p[i % NGRP] = p[i % NGRP] ^ d[i];
    return p;
  endfunction

  logic [DW-1:0]   dmem [DEPTH];
  logic [NGRP-1:0] pmem [DEPTH];
  logic [DEPTH-1:0] vld;

  logic [1:0] arm;
  logic [2:0] status, ien;
  logic [1:0] cls_sel;
  logic       cache_on;

  logic [NGRP-1:0] rpar_q;
  logic            rvld_q, rinj_q;
  logic [AW-1:0]   raddr_q;

  logic wr_go, rd_go;
  assign wr_go = req_valid &  req_write;
  assign rd_go = req_valid & ~req_write;

  logic csr_arm, csr_stat, csr_cfg, csr_ien;
  assign csr_arm  = csr_write && csr_addr == 2'd0;
  assign csr_stat = csr_write && csr_addr == 2'd1;
  assign csr_cfg  = csr_write && csr_addr == 2'd2;
  assign csr_ien  = csr_write && csr_addr == 2'd3;

  logic [2:0] cls_oh;
  assign cls_oh = (cls_sel == 2'd0) ? 3'b001 :
                  (cls_sel == 2'd1) ? 3'b010 : 3'b100;

  logic chk_fail;
  assign chk_fail = (|(grp_par(rsp_rdata) ^ rpar_q)) ^ rinj_q;
  assign rsp_perr = rsp_valid & chk_fail;
  assign rsp_miss = rsp_valid & cache_on & (~rvld_q | chk_fail);

  logic [2:0] clr_mask;
  assign clr_mask = csr_stat ? csr_wdata[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (wr_go) begin
      dmem[req_addr] <= req_wdata;
      pmem[req_addr] <= grp_par(req_wdata) ^ {NGRP{arm[0]}};
    end
    if (rd_go) begin
      rsp_rdata <= dmem[req_addr];
      rpar_q    <= pmem[req_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld       <= '0;
      arm       <= '0;
      status    <= '0;
      ien       <= '0;
      cls_sel   <= '0;
      cache_on  <= 1'b0;
      rsp_valid <= 1'b0;
      rvld_q    <= 1'b0;
      rinj_q    <= 1'b0;
      raddr_q   <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) begin
        rvld_q  <= vld[req_addr];
        rinj_q  <= arm[1];
        raddr_q <= req_addr;
      end
      if (rsp_perr && cache_on) vld[raddr_q] <= 1'b0;
      if (wr_go) vld[req_addr] <= 1'b1;
      arm <= (arm & ~{rd_go, wr_go}) | (csr_arm ? csr_wdata[1:0] : 2'b00);
      status <= (status & ~clr_mask) | (rsp_perr ? cls_oh : 3'b000);
      if (csr_cfg) begin
        cls_sel  <= csr_wdata[1:0];
        cache_on <= csr_wdata[4];
      end
      if (csr_ien) ien <= csr_wdata[2:0];
    end
  end

  always_comb begin
    case (csr_addr)
      2'd0:    csr_rdata = {6'b0, arm};
      2'd1:    csr_rdata = {5'b0, status};
      2'd2:    csr_rdata = {3'b0, cache_on, 2'b0, cls_sel};
      default: csr_rdata = {5'b0, ien};
    endcase
  end

  assign irq = status & ien;

  a_r9_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rsp_valid);
  a_r9_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !rsp_valid);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(|($past(status) & ~status & ~$past(clr_mask))));
  a_r6_class_set: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perr |=> |(status & $past(cls_oh)));
  a_r3_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && arm[0] && !(csr_arm && csr_wdata[0])) |=> !arm[0]);
  a_r4_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && arm[1] && !(csr_arm && csr_wdata[1])) |=> !arm[1]);
  a_r8_miss_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_perr && cache_on) |-> rsp_miss);
  a_r8_line_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_perr && cache_on && !(wr_go && req_addr == raddr_q)) |=> !vld[$past(raddr_q)]);
  a_r8_no_miss_plain: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_on |-> !rsp_miss);

endmodule

// File: tb/parity_guard_ram_bench.sv
`timescale 1ns/1ps
module parity_guard_ram_bench;
  localparam int DW = 16, DEPTH = 16, NGRP = 4, AW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, rsp_perr, rsp_miss;
  logic [DW-1:0] rsp_rdata;
  logic csr_write = 0;
  logic [1:0] csr_addr = '0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic [2:0] irq;

  int checks = 0, errors = 0;
  logic [DW-1:0] shadow [DEPTH];

  always #4 clk = ~clk;

  parity_guard_ram #(.DW(DW), .DEPTH(DEPTH), .NGRP(NGRP)) u_parity_guard_ram (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_rdata, .rsp_perr, .rsp_miss,
    .csr_write, .csr_addr, .csr_wdata, .csr_rdata, .irq);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    shadow[a] = d;
  endtask

  logic [DW-1:0] got_d;
  logic got_v, got_e, got_m;
  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    got_v = rsp_valid; got_d = rsp_rdata; got_e = rsp_perr; got_m = rsp_miss;
  endtask

  task automatic csr_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    csr_write = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_write = 0;
  endtask

  logic [7:0] rd8;
  task automatic csr_rd(input logic [1:0] a);
    @(negedge clk);
    csr_addr = a;
    #1 rd8 = csr_rdata;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    for (int r = 0; r < 4; r++) begin
      csr_rd(r[1:0]);
      chk("R10 reg reset", rd8, 8'h00);
    end
    chk("R10 irq reset", irq, 3'b000);

    // R1 / R9 clean sweep
    for (int a = 0; a < DEPTH; a++) do_write(a[AW-1:0], DW'((a * 16'h1357) ^ 16'hA5C3));
    for (int a = 0; a < DEPTH; a++) begin
      do_read(a[AW-1:0]);
      chk("R9 rsp_valid", got_v, 1'b1);
      chk("R1 data", got_d, shadow[a]);
      chk("R1 no error", got_e, 1'b0);
      chk("R8 no miss plain", got_m, 1'b0);
    end
    @(negedge clk);
    chk("R9 write no response", rsp_valid, 1'b0);

    // R2 burst sweep and R1 same-group pair
    for (int len = 1; len <= NGRP; len++)
      for (int s = 0; s + len <= DW; s++) begin
        logic [DW-1:0] m;
        m = DW'(((1 << len) - 1) << s);
        u_parity_guard_ram.dmem[3] = shadow[3] ^ m;
        do_read(4'd3);
        chk("R2 burst flagged", got_e, 1'b1);
        chk("R2 stored data", got_d, shadow[3] ^ m);
      end
    for (int k = 0; k < NGRP; k++) begin
      u_parity_guard_ram.dmem[3] = shadow[3] ^ DW'((1 << k) | (1 << (k + NGRP)));
      do_read(4'd3);
      chk("R1 same group pair unseen", got_e, 1'b0);
    end
    do_write(4'd3, shadow[3]);
    csr_wr(2'd1, 8'h07);
    csr_rd(2'd1);
    chk("R5 w1c clears", rd8, 8'h00);

    // R3 write-side injection, arm in same cycle as write
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 4'd5; req_wdata = 16'h1234;
    csr_write = 1; csr_addr = 2'd0; csr_wdata = 8'h01;
    @(negedge clk);
    req_valid = 0; req_write = 0; csr_write = 0;
    shadow[5] = 16'h1234;
    do_read(4'd5);
    chk("R3 same-cycle arm not used", got_e, 1'b0);
    csr_rd(2'd0);
    chk("R4 arm readback", rd8, 8'h01);
    do_write(4'd6, 16'hBEEF);
    csr_rd(2'd0);
    chk("R3 arm cleared", rd8, 8'h00);
    do_read(4'd6);
    chk("R3 error flagged", got_e, 1'b1);
    chk("R3 true data", got_d, 16'hBEEF);
    do_read(4'd7);
    chk("R3 one shot", got_e, 1'b0);

    // R4 read-side injection
    csr_wr(2'd0, 8'h02);
    do_read(4'd6);
    chk("R4 inverted on bad word", got_e, 1'b0);
    do_read(4'd6);
    chk("R4 one shot", got_e, 1'b1);
    csr_wr(2'd0, 8'h02);
    do_read(4'd8);
    chk("R4 clean word flagged", got_e, 1'b1);
    chk("R4 true data", got_d, shadow[8]);
    chk("R8 miss stays 0 plain", got_m, 1'b0);

    // R6 / R7 classes and interrupts
    csr_wr(2'd1, 8'h07);
    csr_wr(2'd3, 8'h05);
    csr_wr(2'd2, 8'h02);
    do_read(4'd6);
    csr_rd(2'd1);
    chk("R6 fatal class", rd8, 8'h04);
    chk("R7 irq fatal", irq, 3'b100);
    csr_wr(2'd2, 8'h00);
    do_read(4'd6);
    csr_rd(2'd1);
    chk("R6 correctable class", rd8, 8'h05);
    chk("R7 irq corr+fatal", irq, 3'b101);
    csr_wr(2'd2, 8'h01);
    do_read(4'd6);
    csr_rd(2'd1);
    chk("R6 nonfatal class", rd8, 8'h07);
    chk("R7 nonfatal masked", irq, 3'b101);
    csr_wr(2'd2, 8'h03);
    csr_wr(2'd1, 8'h04);
    do_read(4'd6);
    csr_rd(2'd1);
    chk("R6 code 3 fatal", rd8, 8'h07);
    csr_wr(2'd1, 8'h02);
    csr_rd(2'd1);
    chk("R5 clear one bit", rd8, 8'h05);

    // R5 set wins over same-cycle clear
    csr_wr(2'd1, 8'h07);
    csr_wr(2'd2, 8'h00);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 4'd6;
    @(negedge clk);
    req_valid = 0;
    chk("R9 error with response", rsp_perr, 1'b1);
    csr_write = 1; csr_addr = 2'd1; csr_wdata = 8'h01;
    @(negedge clk);
    csr_write = 0;
    csr_rd(2'd1);
    chk("R5 set wins", rd8, 8'h01);

    // R8 cache mode
    csr_wr(2'd2, 8'h10);
    do_write(4'd9, 16'h0F0F);
    do_read(4'd9);
    chk("R8 hit", got_m, 1'b0);
    csr_wr(2'd0, 8'h02);
    do_read(4'd9);
    chk("R8 error miss", got_m, 1'b1);
    chk("R8 error flag", got_e, 1'b1);
    do_read(4'd9);
    chk("R8 invalid clean", got_e, 1'b0);
    chk("R8 line dropped", got_m, 1'b1);
    do_write(4'd9, 16'h0F0F);
    do_read(4'd9);
    chk("R8 refill hits", got_m, 1'b0);
    chk("R8 refill data", got_d, 16'h0F0F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule